// File: doc/BRIEF.md
# Pipeline Hazard Controller

This block is the hazard and bypass control for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) that has a program-counter register in front of fetch. Each cycle it reads the operation code held in decode, execute and memory, the two source register identifiers in decode, the ALU and memory destination identifiers in execute, memory and writeback, and a wrong-branch flag from execute. From these it drives a hold (stall) and a flush (bubble) signal for each of the five pipeline registers, and a bypass select code for each of the two decode operands.

The control path is purely combinational. Flushing a register loads it with a no-op whose destinations are the null register and whose other fields are zero. Branches are fetched along the taken path. A wrong guess is repaired by flushing the two younger instructions. A load whose result is needed at once costs one hold cycle. A return freezes fetch until its target has been read from memory. Every other dependence is covered by bypassing. The clock and reset inputs serve only the built-in property checks.

Top module: `hz_ctrl`

## Requirements
- R1: With no load/use match, no wrong branch and no return in decode, execute or memory, every stall and bubble output is 0.
- R2: When execute holds a memory read (operation code 0x5 load or 0xB pop) and its memory destination equals a decode source, the PC and decode registers stall and the execute register takes a bubble. No other register is held or flushed.
- R3: The null register identifier 0xF never causes a stall or a bypass, even when source and destination are both 0xF.
- R4: A wrong-branch flag from execute flushes the decode and execute registers and stalls nothing.
- R5: When a wrong branch and a load/use match occur together, the flush of R4 applies and no stall is raised.
- R6: A return (operation code 0x9) in decode, execute or memory, with no load/use match and no wrong branch, stalls the PC register and flushes decode.
- R7: A return together with a load/use match gives the R2 outputs: decode is held, not flushed.
- R8: Each operand's bypass select follows this priority. Execute ALU result (1) comes first, then memory-stage memory result (2), then memory-stage ALU result (3), then writeback memory result (4), then writeback ALU result (5). With no match the select is register file (0).
- R9: No pipeline register ever has stall and bubble asserted together. The memory and writeback registers always load normally.
- R10: The memory destination of the instruction in execute is never a bypass source; a match on it by a non-load produces select 0 and no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock for the property checks |
| rst_ni | input | 1 | Active-low asynchronous reset for the checks |
| d_icode_i | input | OP_W | Operation code in decode |
| d_src_a_i | input | REG_W | First source register in decode |
| d_src_b_i | input | REG_W | Second source register in decode |
| e_icode_i | input | OP_W | Operation code in execute |
| e_dst_e_i | input | REG_W | ALU destination in execute |
| e_dst_m_i | input | REG_W | Memory destination in execute |
| e_mispredict_i | input | 1 | Wrong branch detected in execute |
| m_icode_i | input | OP_W | Operation code in memory stage |
| m_dst_e_i | input | REG_W | ALU destination in memory stage |
| m_dst_m_i | input | REG_W | Memory destination in memory stage |
| w_dst_e_i | input | REG_W | ALU destination in writeback |
| w_dst_m_i | input | REG_W | Memory destination in writeback |
| p_stall_o | output | 1 | Hold PC register |
| p_bubble_o | output | 1 | Flush PC register |
| d_stall_o | output | 1 | Hold decode register |
| d_bubble_o | output | 1 | Flush decode register |
| e_stall_o | output | 1 | Hold execute register |
| e_bubble_o | output | 1 | Flush execute register |
| m_stall_o | output | 1 | Hold memory register |
| m_bubble_o | output | 1 | Flush memory register |
| w_stall_o | output | 1 | Hold writeback register |
| w_bubble_o | output | 1 | Flush writeback register |
| fwd_a_o | output | 3 | Bypass select, first operand |
| fwd_b_o | output | 3 | Bypass select, second operand |

## Verification
The bench builds the block with its default 4-bit register identifiers and 4-bit operation codes. At that width the null identifier 0xF, the load, pop and return codes, and every one of the fifteen real registers can be reached directly. The width also lets the same identifier be placed in all five destination slots at once, so the whole bypass priority chain is tested one rung at a time. Coincident cases are driven on purpose: a return with a load/use match, a wrong branch with a load/use match, and a return with a wrong branch.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int FWD_W = 3;
  typedef enum logic [FWD_W-1:0] {
    FWD_RF    = 3'd0,
    FWD_E_ALU = 3'd1,
    FWD_M_MEM = 3'd2,
    FWD_M_ALU = 3'd3,
    FWD_W_MEM = 3'd4,
    FWD_W_ALU = 3'd5
  } fwd_e;

  localparam int NSTG = 5;
  typedef enum int { STG_P = 0, STG_D = 1, STG_E = 2, STG_M = 3, STG_W = 4 } stg_e;
endpackage

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel #(
  parameter int REG_W = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [REG_W-1:0]        src_i,
  input  logic [REG_W-1:0]        e_dst_e_i,
  input  logic [REG_W-1:0]        m_dst_e_i,
  input  logic [REG_W-1:0]        m_dst_m_i,
  input  logic [REG_W-1:0]        w_dst_e_i,
  input  logic [REG_W-1:0]        w_dst_m_i,
  output logic [hz_pkg::FWD_W-1:0] sel_o
);
  import hz_pkg::*;
  localparam logic [REG_W-1:0] NO_REG = '1;

  logic live;
  assign live = (src_i != NO_REG);

  // youngest producer wins; memory result before ALU result within a stage
  always_comb begin
    sel_o = FWD_RF;
    if (live) begin
      if      (src_i == e_dst_e_i) sel_o = FWD_E_ALU;
      else if (src_i == m_dst_m_i) sel_o = FWD_M_MEM;
      else if (src_i == m_dst_e_i) sel_o = FWD_M_ALU;
      else if (src_i == w_dst_m_i) sel_o = FWD_W_MEM;
      else if (src_i == w_dst_e_i) sel_o = FWD_W_ALU;
    end
  end

  // R3
  noreg_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == NO_REG) |-> (sel_o == FWD_RF));
  // R8
  fwd_e_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o == FWD_E_ALU) |-> (e_dst_e_i == src_i));
  // R8
  fwd_m_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o == FWD_M_ALU) |-> (m_dst_m_i != src_i && e_dst_e_i != src_i));
endmodule

// File: rtl/hz_detect.sv
module hz_detect #(
  parameter int             REG_W   = 4,
  parameter int             OP_W    = 4,
  parameter logic [OP_W-1:0] OP_LOAD = 4'h5,
  parameter logic [OP_W-1:0] OP_POP  = 4'hB,
  parameter logic [OP_W-1:0] OP_RET  = 4'h9
) (
  input  logic [OP_W-1:0]  d_icode_i,
  input  logic [REG_W-1:0] d_src_a_i,
  input  logic [REG_W-1:0] d_src_b_i,
  input  logic [OP_W-1:0]  e_icode_i,
  input  logic [REG_W-1:0] e_dst_m_i,
  input  logic [OP_W-1:0]  m_icode_i,
  output logic             load_use_o,
  output logic             ret_pend_o
);
  localparam logic [REG_W-1:0] NO_REG = '1;

  logic e_is_rd;
  assign e_is_rd    = (e_icode_i == OP_LOAD) || (e_icode_i == OP_POP);
  assign load_use_o = e_is_rd && (e_dst_m_i != NO_REG) &&
                      ((e_dst_m_i == d_src_a_i) || (e_dst_m_i == d_src_b_i));
  assign ret_pend_o = (d_icode_i == OP_RET) || (e_icode_i == OP_RET) ||
                      (m_icode_i == OP_RET);
endmodule

// File: rtl/hz_pipe_ctl.sv
module hz_pipe_ctl (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_use_i,
  input  logic                    ret_pend_i,
  input  logic                    mispredict_i,
  output logic [hz_pkg::NSTG-1:0] stall_o,
  output logic [hz_pkg::NSTG-1:0] bubble_o
);
  import hz_pkg::*;

  logic lu, rw;
  assign lu = load_use_i && !mispredict_i;  // squash wins
  assign rw = ret_pend_i && !mispredict_i;

  always_comb begin
    stall_o  = '0;
    bubble_o = '0;
    stall_o[STG_P]  = lu || rw;
    stall_o[STG_D]  = lu;
    bubble_o[STG_D] = mispredict_i || (rw && !lu);
    bubble_o[STG_E] = mispredict_i || lu;
  end

  genvar g;
  generate
    for (g = 0; g < NSTG; g++) begin : g_excl
      // R9
      sb_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(stall_o[g] && bubble_o[g]));
    end
  endgenerate

  // R4
  squash_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mispredict_i |-> (stall_o == '0 && bubble_o[STG_D] && bubble_o[STG_E]));
  // R2
  interlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_use_i && !mispredict_i) |-> (stall_o[STG_P] && stall_o[STG_D] && bubble_o[STG_E]));
  // R6
  ret_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_pend_i && !load_use_i && !mispredict_i) |-> (stall_o[STG_P] && bubble_o[STG_D]));
endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl #(
  parameter int             REG_W   = 4,
  parameter int             OP_W    = 4,
  parameter logic [OP_W-1:0] OP_LOAD = 4'h5,
  parameter logic [OP_W-1:0] OP_POP  = 4'hB,
  parameter logic [OP_W-1:0] OP_RET  = 4'h9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OP_W-1:0]  d_icode_i,
  input  logic [REG_W-1:0] d_src_a_i,
  input  logic [REG_W-1:0] d_src_b_i,
  input  logic [OP_W-1:0]  e_icode_i,
  input  logic [REG_W-1:0] e_dst_e_i,
  input  logic [REG_W-1:0] e_dst_m_i,
  input  logic             e_mispredict_i,
  input  logic [OP_W-1:0]  m_icode_i,
  input  logic [REG_W-1:0] m_dst_e_i,
  input  logic [REG_W-1:0] m_dst_m_i,
  input  logic [REG_W-1:0] w_dst_e_i,
  input  logic [REG_W-1:0] w_dst_m_i,
  output logic             p_stall_o,
  output logic             p_bubble_o,
  output logic             d_stall_o,
  output logic             d_bubble_o,
  output logic             e_stall_o,
  output logic             e_bubble_o,
  output logic             m_stall_o,
  output logic             m_bubble_o,
  output logic             w_stall_o,
  output logic             w_bubble_o,
  output logic [2:0]       fwd_a_o,
  output logic [2:0]       fwd_b_o
);
  import hz_pkg::*;
  localparam int NOPS = 2;

  logic load_use, ret_pend;
  logic [NSTG-1:0] stall, bubble;
  logic [REG_W-1:0] src [NOPS];
  logic [FWD_W-1:0] fwd [NOPS];

  hz_detect #(.REG_W(REG_W), .OP_W(OP_W), .OP_LOAD(OP_LOAD), .OP_POP(OP_POP),
              .OP_RET(OP_RET)) u_det (
    .d_icode_i (d_icode_i), .d_src_a_i (d_src_a_i), .d_src_b_i (d_src_b_i),
    .e_icode_i (e_icode_i), .e_dst_m_i (e_dst_m_i), .m_icode_i (m_icode_i),
    .load_use_o(load_use),  .ret_pend_o(ret_pend)
  );

  hz_pipe_ctl u_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_use_i(load_use), .ret_pend_i(ret_pend),
    .mispredict_i(e_mispredict_i), .stall_o(stall), .bubble_o(bubble)
  );

  assign src[0] = d_src_a_i;
  assign src[1] = d_src_b_i;

  genvar g;
  generate
    for (g = 0; g < NOPS; g++) begin : g_op
      hz_fwd_sel #(.REG_W(REG_W)) u_fwd (
        .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src[g]),
        .e_dst_e_i(e_dst_e_i), .m_dst_e_i(m_dst_e_i), .m_dst_m_i(m_dst_m_i),
        .w_dst_e_i(w_dst_e_i), .w_dst_m_i(w_dst_m_i), .sel_o(fwd[g])
      );
    end
  endgenerate

  assign fwd_a_o    = fwd[0];
  assign fwd_b_o    = fwd[1];
  assign p_stall_o  = stall[STG_P];
  assign p_bubble_o = bubble[STG_P];
  assign d_stall_o  = stall[STG_D];
  assign d_bubble_o = bubble[STG_D];
  assign e_stall_o  = stall[STG_E];
  assign e_bubble_o = bubble[STG_E];
  assign m_stall_o  = stall[STG_M];
  assign m_bubble_o = bubble[STG_M];
  assign w_stall_o  = stall[STG_W];
  assign w_bubble_o = bubble[STG_W];

  // R9
  mw_normal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(m_stall_o || m_bubble_o || w_stall_o || w_bubble_o));
  // R10
  stall_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_stall_o |-> (e_dst_m_i != '1 && (e_dst_m_i == d_src_a_i || e_dst_m_i == d_src_b_i)));
endmodule

// File: tb/tb_hz_ctrl.sv
`timescale 1ns/1ps
module tb_hz_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [3:0] d_ic, d_sa, d_sb, e_ic, e_de, e_dm, m_ic, m_de, m_dm, w_de, w_dm;
  logic       e_mp;
  logic p_s, p_b, d_s, d_b, e_s, e_b, m_s, m_b, w_s, w_b;
  logic [2:0] fa, fb;
  int n_run = 0, n_fail = 0;

  hz_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .d_icode_i(d_ic), .d_src_a_i(d_sa), .d_src_b_i(d_sb),
    .e_icode_i(e_ic), .e_dst_e_i(e_de), .e_dst_m_i(e_dm), .e_mispredict_i(e_mp),
    .m_icode_i(m_ic), .m_dst_e_i(m_de), .m_dst_m_i(m_dm), .w_dst_e_i(w_de), .w_dst_m_i(w_dm),
    .p_stall_o(p_s), .p_bubble_o(p_b), .d_stall_o(d_s), .d_bubble_o(d_b),
    .e_stall_o(e_s), .e_bubble_o(e_b), .m_stall_o(m_s), .m_bubble_o(m_b),
    .w_stall_o(w_s), .w_bubble_o(w_b), .fwd_a_o(fa), .fwd_b_o(fb)
  );

  // {p_s,p_b,d_s,d_b,e_s,e_b,m_s,m_b,w_s,w_b}
  localparam logic [9:0] CTL_NONE = 10'b00_00_00_00_00;
  localparam logic [9:0] CTL_LU   = 10'b10_10_01_00_00;
  localparam logic [9:0] CTL_SQ   = 10'b00_01_01_00_00;
  localparam logic [9:0] CTL_RET  = 10'b10_01_00_00_00;

  function automatic logic [9:0] ctl();
    return {p_s, p_b, d_s, d_b, e_s, e_b, m_s, m_b, w_s, w_b};
  endfunction

  task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic idle();
    d_ic = 4'h1; e_ic = 4'h1; m_ic = 4'h1;
    d_sa = 4'hF; d_sb = 4'hF; e_de = 4'hF; e_dm = 4'hF;
    m_de = 4'hF; m_dm = 4'hF; w_de = 4'hF; w_dm = 4'hF; e_mp = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    settle();
    chk("R1 idle ctl", ctl(), CTL_NONE);
    chk("R1 idle fwd", {4'b0, fa, fb}, 10'd0);
  endtask

  task automatic t_forward();
    idle(); d_sa = 4'd2; d_sb = 4'd3; d_ic = 4'h6;
    e_de = 4'd2; m_dm = 4'd2; m_de = 4'd2; w_dm = 4'd2; w_de = 4'd2; settle();
    chk("R8 E first", {7'b0, fa}, 10'd1);
    chk("R1 fwd no stall", ctl(), CTL_NONE);
    e_de = 4'hF; settle();
    chk("R8 M mem", {7'b0, fa}, 10'd2);
    m_dm = 4'hF; settle();
    chk("R8 M alu", {7'b0, fa}, 10'd3);
    m_de = 4'hF; settle();
    chk("R8 W mem", {7'b0, fa}, 10'd4);
    w_dm = 4'hF; settle();
    chk("R8 W alu", {7'b0, fa}, 10'd5);
    w_de = 4'hF; settle();
    chk("R8 regfile", {7'b0, fa}, 10'd0);
    m_de = 4'd3; w_dm = 4'd3; settle();
    chk("R8 operand b", {7'b0, fb}, 10'd3);
  endtask

  task automatic t_noreg();
    idle(); e_ic = 4'h5; settle();
    chk("R3 null load no stall", ctl(), CTL_NONE);
    chk("R3 null no fwd", {4'b0, fa, fb}, 10'd0);
  endtask

  task automatic t_edstm();
    idle(); e_ic = 4'h6; e_dm = 4'd7; d_sa = 4'd7; settle();
    chk("R10 no stall", ctl(), CTL_NONE);
    chk("R10 no fwd", {7'b0, fa}, 10'd0);
  endtask

  task automatic t_loaduse();
    idle(); e_ic = 4'h5; e_dm = 4'd4; d_sb = 4'd4; settle();
    chk("R2 load", ctl(), CTL_LU);
    idle(); e_ic = 4'hB; e_dm = 4'd6; d_sa = 4'd6; settle();
    chk("R2 pop", ctl(), CTL_LU);
    idle(); e_ic = 4'h5; e_dm = 4'd6; d_sa = 4'd5; settle();
    chk("R1 load no match", ctl(), CTL_NONE);
  endtask

  task automatic t_mispredict();
    idle(); e_ic = 4'h7; e_mp = 1'b1; settle();
    chk("R4 squash", ctl(), CTL_SQ);
    idle(); e_ic = 4'h5; e_dm = 4'd4; d_sa = 4'd4; e_mp = 1'b1; settle();
    chk("R5 squash over interlock", ctl(), CTL_SQ);
    idle(); d_ic = 4'h9; e_mp = 1'b1; settle();
    chk("R4 ret on wrong path", ctl(), CTL_SQ);
  endtask

  task automatic t_ret();
    idle(); d_ic = 4'h9; settle();
    chk("R6 ret in D", ctl(), CTL_RET);
    idle(); e_ic = 4'h9; settle();
    chk("R6 ret in E", ctl(), CTL_RET);
    idle(); m_ic = 4'h9; settle();
    chk("R6 ret in M", ctl(), CTL_RET);
    idle(); d_ic = 4'h9; d_sa = 4'd4; e_ic = 4'h5; e_dm = 4'd4; settle();
    chk("R7 ret with interlock", ctl(), CTL_LU);
  endtask

  initial begin
    idle();
    #1;
    t_reset();
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_forward();
    t_noreg();
    t_edstm();
    t_loaduse();
    t_mispredict();
    t_ret();
    // R9 covered by every ctl vector above (m/w bits always expected 0)
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #20000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule